// File: doc/BRIEF.md
# Synchronous Serial Frame Receiver

This block takes in character frames on a single serial data line in clocked (synchronous) mode. The shift clock either comes from the block itself, divided down from the system clock, or is taken from an external pin. A polarity setting picks the shift-clock edge on which the line is sampled. The line is expected to change on the opposite edge.

While the line is idle it sits high. A frame opens with a low start bit, followed by 5 to 9 data bits sent least significant first. An even or odd parity bit may follow the data, and the frame closes with a high stop bit. The data width and the parity mode are set at runtime through configuration inputs. Each received word is presented with its parity-error, framing-error and overrun flags on a valid/ready output stage one word deep.

The external shift clock and the data input are brought into the system clock domain through two-flop synchronizers. The generated clock runs freely whenever the block is in master mode.

Top module: `sync_frame_rx`

## Requirements
- R1: With `cfg_master`=1, `sclk_out` toggles every `cfg_half`+1 system clocks and is the shift clock. With `cfg_master`=0, `sclk_out` is held low and the shift clock is `sclk_in`.
- R2: With `cfg_pol`=0 the line is sampled on the falling shift-clock edge. With `cfg_pol`=1 it is sampled on the rising edge.
- R3: While idle, high samples are ignored and no word is produced. The first low sample starts a frame.
- R4: The data bits arrive least significant first, and their count is `cfg_bits` clamped to the range 5..9. Bit i of `rx_word` is the i-th data bit received, and bits at or above the count are zero.
- R5: `cfg_par` encodes the parity mode: 2'b10 even, 2'b11 odd, and 2'b00/2'b01 none. With parity enabled, one parity bit follows the data bits. `rx_perr` is set when the XOR of the data bits and the parity bit is not 0 (even) or not 1 (odd). With parity off, `rx_perr` is 0.
- R6: The sample after the data bits (or after the parity bit) is the stop bit, and a low stop bit sets `rx_ferr`. Only this one stop position is checked. After it the receiver returns to idle, so a second stop bit needs no setting.
- R7: If a frame completes while `rx_valid`=1 and `rx_ready`=0, the new word is dropped, the held word and its error flags are kept, and `rx_ovr` is set.
- R8: `rx_word`, `rx_perr`, `rx_ferr` and `rx_ovr` stay stable while `rx_valid`=1 and `rx_ready`=0. On a cycle with both high the word is taken: `rx_valid` falls on the next cycle and `rx_ovr` clears.
- R9: After reset, `rx_valid`=0, `rx_ovr`=0 and `sclk_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1: generate the shift clock; 0: use sclk_in |
| cfg_half | input | DIVW | Half period of the generated shift clock, minus one, in system clocks (at least 3) |
| cfg_pol | input | 1 | Sampling edge: 0 falling, 1 rising |
| cfg_bits | input | 4 | Data bit count, clamped to 5..9 |
| cfg_par | input | 2 | Parity mode: 10 even, 11 odd, else none |
| sclk_in | input | 1 | External shift clock (slave mode) |
| sclk_out | output | 1 | Generated shift clock (master mode) |
| rxd | input | 1 | Serial data line, idle high |
| rx_valid | output | 1 | Received word is available |
| rx_ready | input | 1 | Consumer takes the word |
| rx_word | output | 9 | Received data, zero-extended |
| rx_perr | output | 1 | Parity error for the held word |
| rx_ferr | output | 1 | Framing error for the held word |
| rx_ovr | output | 1 | At least one frame was dropped while the word was held |

## Verification
The bench acts as the transmitter. It covers both clock sources and both polarities, since sampling on the wrong edge would catch the line mid-change and scramble the bits. Data widths outside 5..9 check the clamping. Random upper data bits catch a receiver that leaves stale or unmasked bits above the configured count. Frames with a corrupted parity bit and a low stop bit must set exactly the matching flag. A second frame sent while the first is still unread must leave the first word in place with the overrun flag set, where a faulty design would overwrite it or lose the flag.

// File: rtl/sync_frame_rx.sv
module sync_frame_rx #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_master,
  input  logic [DIVW-1:0] cfg_half,
  input  logic            cfg_pol,
  input  logic [3:0]      cfg_bits,
  input  logic [1:0]      cfg_par,
  input  logic            sclk_in,
  output logic            sclk_out,
  input  logic            rxd,
  output logic            rx_valid,
  input  logic            rx_ready,
  output logic [8:0]      rx_word,
  output logic            rx_perr,
  output logic            rx_ferr,
  output logic            rx_ovr
);
  localparam int WMAX = 9;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_PAR, S_STOP} st_t;

  logic [2:0] ck_s;
  logic [1:0] rx_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_s <= '0;
      rx_s <= 2'b11;
    end else begin
      ck_s <= {ck_s[1:0], sclk_in};
      rx_s <= {rx_s[0], rxd};
    end

  logic [DIVW-1:0] div_cnt;
  logic            mclk;
  wire m_wrap = cfg_master && (div_cnt >= cfg_half);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_cnt <= '0;
      mclk    <= 1'b0;
    end else if (!cfg_master) begin
      div_cnt <= '0;
      mclk    <= 1'b0;
    end else if (m_wrap) begin
      div_cnt <= '0;
      mclk    <= ~mclk;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  assign sclk_out = mclk;

  wire s_rise = ck_s[1] & ~ck_s[2];
  wire s_fall = ~ck_s[1] & ck_s[2];
  wire m_tick = m_wrap && (cfg_pol ? ~mclk : mclk);
  wire s_tick = !cfg_master && (cfg_pol ? s_rise : s_fall);
  wire tick   = m_tick | s_tick;
  wire bit_in = rx_s[1];

  wire [3:0] nb = (cfg_bits < 4'd5) ? 4'd5 : (cfg_bits > 4'd9) ? 4'd9 : cfg_bits;
  wire par_en  = cfg_par[1];
  wire par_odd = cfg_par[0];

  st_t          st;
  logic [3:0]   bcnt;
  logic [WMAX-1:0] sh;
  logic         pacc, perr_f;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bcnt <= '0; sh <= '0; pacc <= 1'b0; perr_f <= 1'b0;
    end else if (tick) begin
      unique case (st)
        S_IDLE: if (!bit_in) begin
          st <= S_DATA; bcnt <= '0; sh <= '0; pacc <= 1'b0; perr_f <= 1'b0;
        end
        S_DATA: begin
          sh   <= {bit_in, sh[WMAX-1:1]};
          pacc <= pacc ^ bit_in;
          bcnt <= bcnt + 1'b1;
          if (bcnt == nb - 4'd1) st <= par_en ? S_PAR : S_STOP;
        end
        S_PAR: begin
          perr_f <= (pacc ^ bit_in) != par_odd;
          st     <= S_STOP;
        end
        default: st <= S_IDLE;
      endcase
    end

  wire       done      = tick && (st == S_STOP);
  wire [8:0] done_word = sh >> (4'd9 - nb);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_valid <= 1'b0; rx_word <= '0; rx_perr <= 1'b0; rx_ferr <= 1'b0; rx_ovr <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
        rx_ovr   <= 1'b0;
      end
      if (done) begin
        if (rx_valid && !rx_ready) begin
          rx_ovr <= 1'b1;
        end else begin
          rx_valid <= 1'b1;
          rx_word  <= done_word;
          rx_perr  <= perr_f;
          rx_ferr  <= ~bit_in;
          rx_ovr   <= 1'b0;
        end
      end
    end

  AST_SLAVE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |=> !sclk_out); // R1
  AST_IDLE_WAITS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !tick) |=> st == S_IDLE); // R3
  AST_IDLE_HIGH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && tick && bit_in) |=> st == S_IDLE); // R3
  AST_OVR_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr |-> rx_valid); // R7
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid && $stable(rx_word) && $stable(rx_perr) && $stable(rx_ferr)); // R8
  AST_TAKE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !done) |=> !rx_valid && !rx_ovr); // R8
endmodule

// File: tb/tb_sync_frame_rx.sv
module tb_sync_frame_rx;
  localparam int CLK_PERIOD = 10;
  localparam int DIVW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_master = 1'b0, cfg_pol = 1'b0, sclk_in = 1'b0, rxd = 1'b1, rx_ready = 1'b0;
  logic [DIVW-1:0] cfg_half = 8'd3;
  logic [3:0] cfg_bits = 4'd8;
  logic [1:0] cfg_par = 2'b00;
  logic sclk_out, rx_valid, rx_perr, rx_ferr, rx_ovr;
  logic [8:0] rx_word;
  int total = 0, bad = 0;
  bit finished = 0;

  sync_frame_rx #(.DIVW(DIVW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_half(cfg_half),
    .cfg_pol(cfg_pol), .cfg_bits(cfg_bits), .cfg_par(cfg_par), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .rxd(rxd), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_word(rx_word), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_ovr(rx_ovr));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int nbc(input int b);
    return (b < 5) ? 5 : (b > 9) ? 9 : b;
  endfunction

  function automatic int exp_word(input int d, input int b);
    return d & ((1 << nbc(b)) - 1);
  endfunction

  function automatic bit par_bit(input int d, input int b, input int par);
    return ^exp_word(d, b) ^ par[0];
  endfunction

  function automatic bit chg_level();
    return ~cfg_pol;
  endfunction

  task automatic slot(input bit b);
    if (!cfg_master) begin
      @(negedge clk); sclk_in = chg_level(); rxd = b;
      repeat (int'(cfg_half) + 1) @(negedge clk);
      sclk_in = ~chg_level();
      repeat (int'(cfg_half)) @(negedge clk);
    end else begin
      logic pv;
      forever begin
        pv = sclk_out;
        @(negedge clk);
        if (sclk_out != pv && sclk_out == chg_level()) break;
      end
      rxd = b;
    end
  endtask

  task automatic send(input int d, input bit bad_par, input bit bad_stop);
    slot(1'b0);
    for (int i = 0; i < nbc(int'(cfg_bits)); i++) slot(d[i]);
    if (cfg_par[1]) slot(par_bit(d, int'(cfg_bits), int'(cfg_par)) ^ bad_par);
    slot(~bad_stop);
    slot(1'b1);
    slot(1'b1);
  endtask

  task automatic setup(input bit m, input bit p, input int h, input int b, input int par);
    @(negedge clk);
    cfg_master = m; cfg_pol = p; cfg_half = h[DIVW-1:0];
    cfg_bits = b[3:0]; cfg_par = par[1:0]; rxd = 1'b1;
    sclk_in = p;
    repeat (4 * (h + 1) + 6) @(negedge clk);
  endtask

  task automatic take(input string req, input int w, input bit pe, input bit fe, input bit ov);
    int n = 0;
    while (!rx_valid && n < 200) begin @(negedge clk); n++; end
    chk(req, "valid", int'(rx_valid), 1);
    chk(req, "word", int'(rx_word), w);
    chk(req, "perr", int'(rx_perr), int'(pe));
    chk(req, "ferr", int'(rx_ferr), int'(fe));
    chk(req, "ovr", int'(rx_ovr), int'(ov));
    rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
    chk("R8", "valid after take", int'(rx_valid), 0);
    chk("R8", "ovr after take", int'(rx_ovr), 0);
  endtask

  initial begin
    repeat (5000 * 40) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R9", "reset valid", int'(rx_valid), 0);
    chk("R9", "reset ovr", int'(rx_ovr), 0);
    chk("R9", "reset sclk_out", int'(sclk_out), 0);
    rst_n = 1'b1;

    // R3 idle high line produces nothing
    setup(0, 0, 3, 8, 0);
    repeat (60) begin slot(1'b1); end
    chk("R3", "idle no word", int'(rx_valid), 0);
    chk("R1", "slave sclk_out low", int'(sclk_out), 0);

    // R2 falling-edge sampling, slave
    setup(0, 0, 3, 8, 0);
    send(32'h0A5, 0, 0); take("R2", 'hA5, 0, 0, 0);
    // R2 rising-edge sampling, slave
    setup(0, 1, 4, 8, 0);
    send(32'h13C, 0, 0); take("R2", 'h3C, 0, 0, 0);

    // R1 master period
    setup(1, 1, 5, 8, 0);
    begin
      int n = 0; logic pv;
      pv = sclk_out;
      while (sclk_out == pv) @(negedge clk);
      pv = sclk_out;
      while (sclk_out == pv) begin @(negedge clk); n++; end
      chk("R1", "master half period", n, 6);
    end
    send(32'h0C3, 0, 0); take("R1", 'hC3, 0, 0, 0);

    // R4 clamping and zeroed upper bits
    setup(0, 0, 3, 2, 0);
    send(32'h1FF, 0, 0); take("R4", 'h1F, 0, 0, 0);
    setup(1, 0, 3, 15, 0);
    send(32'h1A6, 0, 0); take("R4", 'h1A6, 0, 0, 0);

    // R5 parity even/odd, good and bad
    setup(0, 1, 3, 7, 2);
    send(32'h05B, 0, 0); take("R5", 'h5B, 0, 0, 0);
    send(32'h05B, 1, 0); take("R5", 'h5B, 1, 0, 0);
    setup(1, 0, 3, 9, 3);
    send(32'h101, 1, 0); take("R5", 'h101, 1, 0, 0);

    // R6 framing error
    setup(0, 0, 3, 6, 0);
    send(32'h02D, 0, 1); take("R6", 'h2D, 0, 1, 0);
    send(32'h012, 0, 0); take("R6", 'h12, 0, 0, 0);

    // R7 overrun keeps first word
    setup(0, 1, 3, 8, 2);
    send(32'h081, 0, 1);
    send(32'h07E, 1, 0);
    chk("R7", "held valid", int'(rx_valid), 1);
    take("R7", 'h81, 0, 1, 1);
    send(32'h044, 0, 0); take("R7", 'h44, 0, 0, 0);

    // random frames
    for (int k = 0; k < 30; k++) begin
      int d, b, par; bit m, p, bp, bs;
      m = 1'($urandom % 2); p = 1'($urandom % 2);
      b = int'($urandom % 16); par = int'($urandom % 4);
      d = int'($urandom % 512);
      bp = ($urandom % 4) == 0; bs = ($urandom % 5) == 0;
      setup(m, p, 3 + int'($urandom % 4), b, par);
      send(d, bp, bs);
      take("R4", exp_word(d, b), bp && par[1], bs, 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule